// File: doc/BRIEF.md
# Readout Capture Buffer with Register Access

This block records wide readout words into an on-chip buffer so that software can inspect them later over a small register bus. While capture is enabled, every input word that arrives with its valid strobe is stored at the current write pointer, and the pointer then steps forward by one, wrapping at the end of the buffer. Software can move either pointer by writing it. It can also switch capture on and off.

Software reads a stored entry by first setting the read pointer. It then reads the entry as a row of 32-bit registers, starting with the least significant piece. The stored word is 230 bits wide and is zero-extended to 256 bits, which gives eight pieces. Both pointers read back with a fixed 16-bit tag in the upper half. Software can use the tag to confirm that it is looking at the right register.

Top module: `readout_capture`

## Requirements
- R1: After reset, the write pointer, read pointer and capture enable are all 0, and `bus_rdata` is 0.
- R2: When capture is enabled and `cap_valid` is high at a clock edge, `cap_data` is stored at the write pointer, and the write pointer increments by one.
- R3: When capture is disabled or `cap_valid` is low, nothing is stored and the write pointer does not change.
- R4: The write pointer wraps from 1023 to 0, and the buffer holds 1024 entries.
- R5: A read of address k (0..7) returns bits [32k+31:32k] of the entry at the read pointer, zero-extended to 256 bits. Address 7 returns bits 229:224 in its low 6 bits, and bits 31:6 are zero.
- R6: Address 8 reads as {16'hBEEF, 6'b0, write pointer}. A write to address 8 loads the write pointer from `bus_wdata[9:0]`. A write in the same cycle as a capture takes priority over the increment, and the captured word still goes to the old pointer.
- R7: Address 9 reads as {16'hCAFE, 6'b0, read pointer}. A write to address 9 loads the read pointer from `bus_wdata[9:0]`.
- R8: Address 0xA reads as {31'b0, enable}. A write to address 0xA sets the capture enable from `bus_wdata[0]` and ignores all other bits.
- R9: Addresses 0xB..0xF read as 0. Writes to addresses 0..7 and 0xB..0xF change nothing.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high, using the state before that edge, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_data | input | 230 | Wide word to capture |
| cap_valid | input | 1 | Qualifies `cap_data` |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is the pointer wrap. Reaching it from the ports would take over a thousand captures. Instead, the stimulus writes the write pointer to 1022 and then captures three words, so the words land at 1022, 1023 and 0. The stimulus then reads those entries back chunk by chunk. A second case drives a pointer write in the same cycle as a capture, which checks both the priority of the write and where the captured word lands.

// File: rtl/readout_capture.sv
module readout_capture #(
  parameter int DATA_W  = 230,
  parameter int ADDR_W  = 10,
  parameter int CHUNK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_valid,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W  = NCHUNK * CHUNK_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic              cap_en;
  logic [31:0]       rd_next;

  wire store   = cap_en & cap_valid;
  wire set_wr  = bus_wr && bus_addr == 4'h8;
  wire set_rd  = bus_wr && bus_addr == 4'h9;
  wire set_en  = bus_wr && bus_addr == 4'hA;
  wire [PAD_W-1:0] padded = PAD_W'(mem[rd_ptr]);

  always_ff @(posedge clk)
    if (store) mem[wr_ptr] <= cap_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cap_en <= 1'b0;
    end else begin
      if (set_wr)     wr_ptr <= bus_wdata[ADDR_W-1:0];
      else if (store) wr_ptr <= wr_ptr + 1'b1;
      if (set_rd) rd_ptr <= bus_wdata[ADDR_W-1:0];
      if (set_en) cap_en <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (int'(bus_addr) < NCHUNK)
      rd_next = padded[int'(bus_addr)*CHUNK_W +: CHUNK_W];
    else if (bus_addr == 4'h8)
      rd_next = {16'hBEEF, 16'(wr_ptr)};
    else if (bus_addr == 4'h9)
      rd_next = {16'hCAFE, 16'(rd_ptr)};
    else if (bus_addr == 4'hA)
      rd_next = {31'b0, cap_en};
  end

  always_ff @(posedge clk)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;

  // R2
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store && !set_wr |=> wr_ptr == $past(wr_ptr) + 1'b1);
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store && !set_wr |=> $stable(wr_ptr));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R6
  wr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 4'h8 |=> bus_rdata[31:16] == 16'hBEEF);
  // R7
  rd_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 4'h9 |=> bus_rdata[31:16] == 16'hCAFE);
  // R8
  en_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 4'hA |=> bus_rdata[31:1] == '0);
  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr > 4'hA |=> bus_rdata == '0);
  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 4'h7 |=> bus_rdata[31:6] == '0);
endmodule

// File: tb/readout_capture_test.sv
`timescale 1ns/1ps
module readout_capture_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [229:0] cap_data = '0;
  logic         cap_valid = 0;
  logic [3:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic         bus_wr = 0, bus_rd = 0;
  logic [31:0]  bus_rdata;

  readout_capture uut (.*);

  always #2.5 clk = ~clk;

  // reference model
  logic [229:0] m_mem [1024];
  logic [9:0]   m_wr, m_rd;
  logic         m_en;
  logic [31:0]  exp_rdata;
  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr = 0; m_rd = 0; m_en = 0; exp_rdata = 0;
    end else begin
      if (bus_rd) begin
        logic [255:0] w;
        w = {26'b0, m_mem[m_rd]};
        if (bus_addr < 8)       exp_rdata = w[bus_addr*32 +: 32];
        else if (bus_addr == 8) exp_rdata = 32'hBEEF0000 | m_wr;
        else if (bus_addr == 9) exp_rdata = 32'hCAFE0000 | m_rd;
        else if (bus_addr == 10) exp_rdata = {31'b0, m_en};
        else                    exp_rdata = 0;
      end
      if (m_en && cap_valid) begin
        m_mem[m_wr] = cap_data;
        m_wr = m_wr + 1;
      end
      if (bus_wr) begin
        if (bus_addr == 8)  m_wr = bus_wdata[9:0];
        if (bus_addr == 9)  m_rd = bus_wdata[9:0];
        if (bus_addr == 10) m_en = bus_wdata[0];
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    checks++;
    if (bus_rdata !== exp_rdata) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h", tag, bus_rdata, exp_rdata);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_rd = 1; bus_addr = a; tick(); bus_rd = 0;
  endtask

  task automatic expect_val(input logic [31:0] v, input string t);
    checks++;
    if (bus_rdata !== v) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, v);
    end
  endtask

  function automatic logic [229:0] rnd();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r[229:0];
  endfunction

  task automatic cap(input logic [229:0] d);
    cap_valid = 1; cap_data = d; tick(); cap_valid = 0;
  endtask

  task automatic read_word(input logic [9:0] a);
    wr(4'h9, {22'b0, a});
    for (int k = 0; k < 8; k++) rd(k[3:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [229:0] keep;
    tag = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    expect_val(32'h0, "R1");
    rd(4'h8); expect_val(32'hBEEF0000, "R1");
    rd(4'h9); expect_val(32'hCAFE0000, "R1");
    rd(4'hA); expect_val(32'h0, "R1");

    tag = "R8";
    wr(4'hA, 32'hFFFF_FFFE); rd(4'hA); expect_val(32'h0, "R8");
    wr(4'hA, 32'h1);         rd(4'hA); expect_val(32'h1, "R8");

    tag = "R2";
    for (int i = 0; i < 5; i++) cap(rnd());
    rd(4'h8); expect_val(32'hBEEF0005, "R2");
    tag = "R5";
    read_word(10'd2);
    read_word(10'd4);
    rd(4'h7);
    checks++;
    if (bus_rdata[31:6] !== 0) begin
      fails++;
      $display("FAIL R5: pad actual %h expected 0", bus_rdata[31:6]);
    end

    tag = "R3";
    repeat (4) tick();
    wr(4'hA, 32'h0);
    cap(rnd()); cap(rnd());
    rd(4'h8); expect_val(32'hBEEF0005, "R3");
    wr(4'h8, 32'h1);
    cap(rnd());
    read_word(10'd1);

    tag = "R4";
    wr(4'hA, 32'h1);
    wr(4'h8, 32'd1022);
    cap(rnd()); cap(rnd());
    rd(4'h8); expect_val(32'hBEEF0000, "R4");
    cap(rnd());
    rd(4'h8); expect_val(32'hBEEF0001, "R4");
    read_word(10'd1023);
    read_word(10'd0);

    tag = "R6";
    keep = rnd();
    cap_valid = 1; cap_data = keep;
    bus_wr = 1; bus_addr = 4'h8; bus_wdata = 32'h0000_0064;
    tick();
    bus_wr = 0; cap_valid = 0;
    rd(4'h8); expect_val(32'hBEEF0064, "R6");
    read_word(10'd1);

    tag = "R7";
    wr(4'h9, 32'hFFFF_F3A5); rd(4'h9); expect_val(32'hCAFE03A5, "R7");

    tag = "R9";
    wr(4'h9, 32'd2);
    wr(4'h3, 32'h1234_5678); wr(4'hC, 32'hFFFF_FFFF); wr(4'hF, 32'h0);
    for (int a = 11; a < 16; a++) rd(a[3:0]);
    read_word(10'd2);
    rd(4'hA); expect_val(32'h1, "R9");

    tag = "R10";
    rd(4'h9);
    bus_addr = 4'h8;
    repeat (3) tick();
    expect_val(32'hCAFE0002, "R10");
    // read concurrent with capture at the read pointer returns the old data
    wr(4'h8, 32'd2);
    cap_valid = 1; cap_data = rnd(); bus_rd = 1; bus_addr = 4'h0;
    tick();
    cap_valid = 0; bus_rd = 0;
    read_word(10'd2);

    finish_run();
  end
endmodule